// File: doc/BRIEF.md
# Stuck Bus Watchdog with Automatic Recovery

This block guards the card side of a two-wire bus buffer. It samples the levels of the output-side clock and data lines every cycle. If either line stays low for a full timeout period, it raises a fault flag. The timeout length is a parameter counted in clock cycles. The fault flag drops as soon as both lines are seen high again.

When the disconnect strap is tied high, a fault also asks the buffer to split the two bus segments. After a settling delay, the block tries to free the bus. It toggles the output clock line through a bounded burst of pulses and then finishes with a stop condition. The burst ends early once the data line reads high while the clock is released. When the strap is low, or the enable input is low, only the fault flag reports the condition.

The timer is held at zero until the supply-good flag is high. A one-cycle timer-reset pulse, which the surrounding logic raises on an enable rising edge, clears the count but leaves the timer running.

Top module: `stuck_bus_guard`

## Requirements
- R1: While supply-good is high and either line reads low, the timer advances by one per cycle. `fault` goes high exactly TIMEOUT_CYC cycles after the first low sample, and it stays high while the low persists.
- R2: A cycle in which both lines read high clears the timer, and `fault` is low in the next cycle. A one-cycle `tmr_clr` pulse also zeroes the count, so a continuing low needs another full TIMEOUT_CYC cycles to raise `fault`.
- R3: `disc_req` equals `fault` while `disc_en` is high, and it is always low while `disc_en` is low.
- R4: With `disc_en` and `enable` high, the recovery starts SETTLE_CYC cycles after `fault` is first seen. Each pulse asserts `scl_pull` for HALF_CYC cycles and then releases it for HALF_CYC cycles. At most PULSES pulses are driven.
- R5: If, during a released half of a pulse, both lines read high, the burst ends and the stop condition begins in the next cycle.
- R6: The stop condition asserts `sda_pull` with `scl_pull` low for HALF_CYC cycles and then releases both. `recov_busy` is high from the settle phase through the stop.
- R7: Whenever `disc_en` or `enable` is low, any recovery in progress is abandoned in the next cycle, with pulls and `recov_busy` low. `fault` keeps reporting.
- R8: While `pwr_good` is low, the timer is held at zero and `fault` stays low. A stuck bus at power-up raises `fault` TIMEOUT_CYC cycles after `pwr_good` rises.
- R9: After a recovery completes or is abandoned, no new recovery starts until `fault` has dropped.
- R10: During reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_lvl | input | 1 | Sampled output-side clock line level |
| sda_lvl | input | 1 | Sampled output-side data line level |
| disc_en | input | 1 | Strap: allow disconnection and recovery |
| enable | input | 1 | Buffer enable; low forbids recovery |
| pwr_good | input | 1 | Supply good; low holds the timer at zero |
| tmr_clr | input | 1 | One-cycle timer clear pulse |
| fault | output | 1 | Stuck-low timeout flag |
| disc_req | output | 1 | Request to disconnect the segments |
| scl_pull | output | 1 | Pull the output clock line low |
| sda_pull | output | 1 | Pull the output data line low |
| recov_busy | output | 1 | Recovery sequence in progress |

## Verification
Two events can land on the same edge: the timer clearing because the data line was freed, and the pulse burst ending early into the stop condition. The bench holds the data line low for two pulses and releases it while the clock is being pulled. On the next released half, both lines read high, so `fault` must fall in the same cycle that `sda_pull` rises. The stop must still last its full length even though the fault has gone. A second collision is an enable drop in the middle of a pulse: the abandon must win over the phase advance.

// File: rtl/stuck_bus_pkg.sv
package stuck_bus_pkg;

    typedef enum logic [2:0] {
        RS_IDLE   = 3'd0,
        RS_SETTLE = 3'd1,
        RS_PULL   = 3'd2,
        RS_FREE   = 3'd3,
        RS_STOP   = 3'd4,
        RS_WAIT   = 3'd5
    } rec_state_e;

    typedef struct packed {
        logic scl_pull;
        logic sda_pull;
        logic busy;
    } drive_t;

    function automatic logic is_active(rec_state_e s);
        return (s == RS_SETTLE) || (s == RS_PULL) ||
               (s == RS_FREE)   || (s == RS_STOP);
    endfunction

    function automatic drive_t drive_of(rec_state_e s);
        drive_t d;
        d.scl_pull = (s == RS_PULL);
        d.sda_pull = (s == RS_STOP);
        d.busy     = is_active(s);
        return d;
    endfunction

endpackage

// File: rtl/stuck_timer.sv
module stuck_timer #(
    parameter int TIMEOUT_CYC = 1_500_000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_lvl,
    input  logic sda_lvl,
    input  logic pwr_good,
    input  logic tmr_clr,
    output logic fault
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(TIMEOUT_CYC);

    logic [CW-1:0] cnt_q;
    logic          both_high;

    assign both_high = scl_lvl && sda_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (!pwr_good || tmr_clr || both_high) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fault = (cnt_q == CNT_MAX);

    AST_CLEAR_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        both_high |=> !fault); // R2
    AST_NO_FAULT_UNPOWERED: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> !fault); // R8
    AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (fault && pwr_good && !tmr_clr && !both_high) |=> fault); // R1

endmodule

// File: rtl/recovery_seq.sv
module recovery_seq
    import stuck_bus_pkg::*;
#(
    parameter int SETTLE_CYC = 2000,
    parameter int HALF_CYC   = 2941,
    parameter int PULSES     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fault,
    input  logic disc_en,
    input  logic enable,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic scl_pull,
    output logic sda_pull,
    output logic busy
);
    localparam int PH_MAX = (SETTLE_CYC > HALF_CYC) ? SETTLE_CYC : HALF_CYC;
    localparam int PW     = $clog2(PH_MAX + 1);
    localparam int NW     = $clog2(PULSES + 1);
    localparam logic [PW-1:0] SET_LAST  = PW'(SETTLE_CYC - 1);
    localparam logic [PW-1:0] HALF_LAST = PW'(HALF_CYC - 1);
    localparam logic [NW-1:0] NP_LAST   = NW'(PULSES - 1);

    rec_state_e    st_q, st_d;
    logic [PW-1:0] ph_q, ph_d;
    logic [NW-1:0] np_q, np_d;
    logic          gate;
    drive_t        drv;

    assign gate = disc_en && enable;

    always_comb begin
        st_d = st_q;
        ph_d = ph_q;
        np_d = np_q;
        case (st_q)
            RS_IDLE: begin
                if (fault && gate) begin
                    st_d = RS_SETTLE;
                    ph_d = '0;
                    np_d = '0;
                end
            end
            RS_SETTLE: begin
                if (!fault) begin
                    st_d = RS_IDLE;
                end else if (ph_q == SET_LAST) begin
                    st_d = RS_PULL;
                    ph_d = '0;
                end else begin
                    ph_d = ph_q + 1'b1;
                end
            end
            RS_PULL: begin
                if (ph_q == HALF_LAST) begin
                    st_d = RS_FREE;
                    ph_d = '0;
                end else begin
                    ph_d = ph_q + 1'b1;
                end
            end
            RS_FREE: begin
                if (scl_lvl && sda_lvl) begin
                    st_d = RS_STOP;
                    ph_d = '0;
                end else if (ph_q == HALF_LAST) begin
                    ph_d = '0;
                    if (np_q == NP_LAST) begin
                        st_d = RS_STOP;
                    end else begin
                        np_d = np_q + 1'b1;
                        st_d = RS_PULL;
                    end
                end else begin
                    ph_d = ph_q + 1'b1;
                end
            end
            RS_STOP: begin
                if (ph_q == HALF_LAST) begin
                    st_d = RS_WAIT;
                    ph_d = '0;
                end else begin
                    ph_d = ph_q + 1'b1;
                end
            end
            RS_WAIT: begin
                if (!fault) st_d = RS_IDLE;
            end
            default: st_d = RS_IDLE;
        endcase
        if (!gate && is_active(st_q)) begin
            st_d = RS_WAIT;
            ph_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RS_IDLE;
            ph_q <= '0;
            np_q <= '0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
            np_q <= np_d;
        end
    end

    assign drv      = drive_of(st_q);
    assign scl_pull = drv.scl_pull;
    assign sda_pull = drv.sda_pull;
    assign busy     = drv.busy;

    AST_GATE_STOPS: assert property (@(posedge clk) disable iff (rst)
        !gate |=> !busy); // R7
    AST_EARLY_STOP: assert property (@(posedge clk) disable iff (rst)
        (st_q == RS_FREE && scl_lvl && sda_lvl && gate) |=> (sda_pull && !scl_pull)); // R5

endmodule

// File: rtl/stuck_bus_guard.sv
module stuck_bus_guard #(
    parameter int TIMEOUT_CYC = 1_500_000,
    parameter int SETTLE_CYC  = 2000,
    parameter int HALF_CYC    = 2941,
    parameter int PULSES      = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_lvl,
    input  logic sda_lvl,
    input  logic disc_en,
    input  logic enable,
    input  logic pwr_good,
    input  logic tmr_clr,
    output logic fault,
    output logic disc_req,
    output logic scl_pull,
    output logic sda_pull,
    output logic recov_busy
);
    logic fault_w;

    stuck_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .pwr_good (pwr_good),
        .tmr_clr  (tmr_clr),
        .fault    (fault_w)
    );

    recovery_seq #(
        .SETTLE_CYC (SETTLE_CYC),
        .HALF_CYC   (HALF_CYC),
        .PULSES     (PULSES)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .fault    (fault_w),
        .disc_en  (disc_en),
        .enable   (enable),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_pull (scl_pull),
        .sda_pull (sda_pull),
        .busy     (recov_busy)
    );

    assign fault    = fault_w;
    assign disc_req = fault_w && disc_en;

    AST_BUSY_NEEDS_STRAP: assert property (@(posedge clk) disable iff (rst)
        recov_busy |-> $past(disc_en && enable)); // R7

endmodule

// File: tb/sim_stuck_bus_guard.sv
module sim_stuck_bus_guard;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 20;
    localparam int ST = 5;
    localparam int HH = 3;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_scl_low = 1'b0, ext_sda_low = 1'b0;
    logic disc_en = 1'b0, enable = 1'b1, pwr_good = 1'b1, tmr_clr = 1'b0;
    logic fault, disc_req, scl_pull, sda_pull, recov_busy;
    logic scl_lvl, sda_lvl;

    assign scl_lvl = !(scl_pull || ext_scl_low);
    assign sda_lvl = !(sda_pull || ext_sda_low);

    stuck_bus_guard #(.TIMEOUT_CYC(TO), .SETTLE_CYC(ST), .HALF_CYC(HH), .PULSES(NP)) u0 (
        .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .disc_en(disc_en), .enable(enable), .pwr_good(pwr_good), .tmr_clr(tmr_clr),
        .fault(fault), .disc_req(disc_req), .scl_pull(scl_pull),
        .sda_pull(sda_pull), .recov_busy(recov_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    int rises = 0, sda_cyc = 0;
    logic prev_scl = 1'b0;
    string scen = "R10";

    // reference model: m_mode 0 idle,1 settle,2 clock low,3 clock free,4 stop,5 wait
    int m_cnt = 0, m_mode = 0, m_ph = 0, m_np = 0;

    task automatic chk(logic act, logic exp, string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (%s) t=%0t actual=%b expected=%b", req, scen, $time, act, exp);
        end
    endtask

    task automatic chk_int(int act, int exp, string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s (%s) t=%0t actual=%0d expected=%0d", req, scen, $time, act, exp);
        end
    endtask

    task automatic model_step();
        bit lscl, lsda, ok, flt;
        int nm;
        lscl = !((m_mode == 2) || ext_scl_low);
        lsda = !((m_mode == 4) || ext_sda_low);
        ok   = disc_en && enable;
        flt  = (m_cnt == TO);
        if (rst) begin
            m_cnt = 0; m_mode = 0; m_ph = 0; m_np = 0;
            return;
        end
        if (!pwr_good || tmr_clr || (lscl && lsda)) m_cnt = 0;
        else if (m_cnt < TO) m_cnt++;
        nm = m_mode;
        if (m_mode == 0) begin
            if (flt && ok) begin nm = 1; m_ph = 0; m_np = 0; end
        end else if (m_mode == 1) begin
            if (!flt) nm = 0;
            else if (m_ph == ST - 1) begin nm = 2; m_ph = 0; end
            else m_ph++;
        end else if (m_mode == 2) begin
            if (m_ph == HH - 1) begin nm = 3; m_ph = 0; end
            else m_ph++;
        end else if (m_mode == 3) begin
            if (lscl && lsda) begin nm = 4; m_ph = 0; end
            else if (m_ph == HH - 1) begin
                m_ph = 0;
                m_np++;
                nm = (m_np == NP) ? 4 : 2;
            end else m_ph++;
        end else if (m_mode == 4) begin
            if (m_ph == HH - 1) begin nm = 5; m_ph = 0; end
            else m_ph++;
        end else begin
            if (!flt) nm = 0;
        end
        if (!ok && m_mode >= 1 && m_mode <= 4) begin nm = 5; m_ph = 0; end
        m_mode = nm;
    endtask

    always @(posedge clk) begin
        bit mf;
        model_step();
        #(CLK_PERIOD/4);
        mf = (m_cnt == TO);
        chk(fault,      mf,                        "R1");
        chk(disc_req,   mf && disc_en,             "R3");
        chk(scl_pull,   m_mode == 2,               "R4");
        chk(sda_pull,   m_mode == 4,               "R6");
        chk(recov_busy, m_mode >= 1 && m_mode <= 4, "R7");
        if (scl_pull && !prev_scl) rises++;
        prev_scl = scl_pull;
        if (sda_pull) sda_cyc++;
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        total++;
        $display("FAIL watchdog expired t=%0t actual=running expected=done", $time);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cycles(3);
        scen = "R10";
        chk(fault, 1'b0, "R10"); chk(scl_pull, 1'b0, "R10");
        chk(sda_pull, 1'b0, "R10"); chk(recov_busy, 1'b0, "R10");
        rst = 1'b0;
        cycles(2);

        // timeout with strap low
        scen = "R1";
        ext_sda_low = 1'b1;
        cycles(TO - 1);
        chk(fault, 1'b0, "R1");
        cycles(1);
        chk(fault, 1'b1, "R1");
        cycles(10);
        scen = "R7";
        chk(recov_busy, 1'b0, "R7"); chk(scl_pull, 1'b0, "R7");
        chk(disc_req, 1'b0, "R3");
        scen = "R2";
        ext_sda_low = 1'b0;
        cycles(1);
        chk(fault, 1'b0, "R2");

        // timer clear pulse restarts the count
        ext_sda_low = 1'b1;
        cycles(15);
        tmr_clr = 1'b1;
        cycles(1);
        tmr_clr = 1'b0;
        cycles(15);
        chk(fault, 1'b0, "R2");
        cycles(5);
        chk(fault, 1'b1, "R2");
        ext_sda_low = 1'b0;
        cycles(2);

        // power-up into a stuck bus
        scen = "R8";
        pwr_good = 1'b0;
        ext_sda_low = 1'b1;
        cycles(40);
        chk(fault, 1'b0, "R8");
        pwr_good = 1'b1;
        cycles(TO - 1);
        chk(fault, 1'b0, "R8");
        cycles(1);
        chk(fault, 1'b1, "R8");
        ext_sda_low = 1'b0;
        cycles(2);

        // full burst against a clock line that never frees
        scen = "R4";
        disc_en = 1'b1;
        rises = 0; sda_cyc = 0;
        ext_scl_low = 1'b1;
        cycles(TO);
        chk(disc_req, 1'b1, "R3");
        cycles(ST + 2 * HH * NP + HH + 5);
        chk_int(rises, NP, "R4");
        chk_int(sda_cyc, HH, "R6");
        scen = "R9";
        chk(recov_busy, 1'b0, "R9");
        chk(fault, 1'b1, "R9");
        cycles(50);
        chk(recov_busy, 1'b0, "R9");
        chk_int(rises, NP, "R9");
        ext_scl_low = 1'b0;
        cycles(3);

        // data frees itself during the burst
        scen = "R5";
        rises = 0; sda_cyc = 0;
        ext_sda_low = 1'b1;
        for (int i = 0; i < 300 && rises < 2; i++) cycles(1);
        ext_sda_low = 1'b0;
        cycles(20);
        chk_int(rises, 2, "R5");
        chk_int(sda_cyc, HH, "R5");
        chk(recov_busy, 1'b0, "R5");
        chk(fault, 1'b0, "R2");

        // enable drop during a pulse
        scen = "R7";
        rises = 0;
        ext_sda_low = 1'b1;
        for (int i = 0; i < 300 && rises < 1; i++) cycles(1);
        enable = 1'b0;
        cycles(1);
        chk(recov_busy, 1'b0, "R7"); chk(scl_pull, 1'b0, "R7");
        cycles(20);
        chk_int(rises, 1, "R7");
        chk(fault, 1'b1, "R7");
        enable = 1'b1;
        cycles(10);
        scen = "R9";
        chk(recov_busy, 1'b0, "R9");
        ext_sda_low = 1'b0;
        cycles(5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule